// File: doc/BRIEF.md
# Two-Wire Serial Settings Receiver

This block turns register writes arriving on a two-wire serial link into single-cycle writes on a parallel settings bus. The link has a clock line and a data line. Both idle high. It carries only writes: there is no acknowledge slot, no device address and no read-back. The system clock oversamples both lines. Each line passes through a register chain before any edge is looked for.

A frame opens with a start condition. The data line falls while the clock line is high. A fixed 40 bits follow, sampled on rising edges of the clock line: first an 8-bit register address, then a 32-bit data word, each most significant bit first, with no gap between them. When the last data bit has been taken, the block raises its strobe for one system clock cycle and presents the new address and data. A stop condition closes the link: the clock line rises while data is low, then data rises while the clock line is high.

The settings output has no back-pressure. The serial master cannot be stalled, so the consumer must accept every strobe in the cycle it appears. Address and data stay steady between strobes, so a consumer may also read them at any later time.

Top module: `ser_set_rx`

## Requirements
- R1: During and right after synchronous active-high reset, the strobe is low and the settings address and data outputs read zero.
- R2: Clock-line rising edges are ignored until a start condition is seen. A start condition is the data line falling while the clock line is high. Bits clocked in without a start produce no strobe and leave the outputs unchanged.
- R3: After a start, the first 8 sampled bits form the address, most significant bit first. The next 32 sampled bits form the data word, most significant bit first. There are no gap or acknowledge bits, and each bit is the data line's level at a clock-line rising edge.
- R4: Each complete 40-bit frame produces exactly one strobe, and that strobe is exactly one system clock cycle wide. It asserts in the cycle after the 40th bit is sampled.
- R5: The address and data outputs change only in the cycle the strobe is high, and hold their values between frames.
- R6: A start condition in the middle of a frame discards the bits received so far and restarts reception at the first address bit.
- R7: A stop condition before all 40 bits have arrived discards the partial frame. No strobe is given and the outputs keep their previous values.
- R8: Clock-line rising edges after the 40th bit and before the next start or stop are ignored and give no further strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous to clk |
| sda_in | input | 1 | Serial data line, asynchronous to clk |
| set_stb | output | 1 | One-cycle strobe marking a new settings write |
| set_addr | output | 8 | Register address of the last complete frame |
| set_data | output | 32 | Data word of the last complete frame |

## Verification
A wrong bit counter or state shows up as a strobe missing, doubled or mistimed. Such an error is visible a few system cycles after the clock-line edge that should have ended the frame. It also shows as an address and data pair shifted by one or more bit positions. A shift register that does not hold shows as outputs that drift between strobes, which can be seen at the very next cycle. A start or stop detector that misfires shows as a frame that is accepted when it should be dropped, or dropped when it should be accepted. The bench compares every strobed pair against values worked out from the transmitted bits.

// File: rtl/ser_set_pkg.sv
package ser_set_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_WAIT = 3'd3
  } state_t;
endpackage

// File: rtl/ser_set_sync.sv
module ser_set_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '1;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '1;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ser_set_edge.sv
module ser_set_edge (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  // Start and stop need the clock line high in both compared samples.
  assign scl_rise  = !scl_prev && scl_s;
  assign start_evt = sda_prev && !sda_s && scl_prev && scl_s;
  assign stop_evt  = !sda_prev && sda_s && scl_prev && scl_s;
endmodule

// File: rtl/ser_set_deser.sv
module ser_set_deser #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              sh_addr,
  input  logic              sh_data,
  input  logic              commit,
  output logic [ADDR_W-1:0] set_addr,
  output logic [DATA_W-1:0] set_data
);
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;
  logic [DATA_W-1:0] data_next;

  assign data_next = {data_sh[DATA_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_sh <= '0;
      data_sh <= '0;
    end else begin
      if (sh_addr) addr_sh <= {addr_sh[ADDR_W-2:0], bit_in};
      if (sh_data) data_sh <= data_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      set_addr <= '0;
      set_data <= '0;
    end else if (commit) begin
      set_addr <= addr_sh;
      set_data <= data_next;
    end
  end
endmodule

// File: rtl/ser_set_rx.sv
module ser_set_rx #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              set_stb,
  output logic [ADDR_W-1:0] set_addr,
  output logic [DATA_W-1:0] set_data
);
  import ser_set_pkg::*;

  localparam int MAX_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  logic [1:0]       lines_s;
  logic             scl_rise, start_evt, stop_evt;
  state_t           state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bit_ev, sh_addr, sh_data, commit;

  ser_set_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_in, sda_in}),
    .dout (lines_s)
  );

  ser_set_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .scl_rise  (scl_rise),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  assign bit_ev  = scl_rise && !start_evt && !stop_evt;
  assign sh_addr = bit_ev && (state_q == ST_ADDR);
  assign sh_data = bit_ev && (state_q == ST_DATA);
  assign commit  = sh_data && (cnt_q == DATA_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      set_stb <= 1'b0;
    end else begin
      set_stb <= commit;
      if (stop_evt) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (start_evt) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else if (sh_addr) begin
        if (cnt_q == ADDR_LAST) begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (sh_data) begin
        if (commit) begin
          state_q <= ST_WAIT;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  ser_set_deser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .bit_in   (lines_s[0]),
    .sh_addr  (sh_addr),
    .sh_data  (sh_data),
    .commit   (commit),
    .set_addr (set_addr),
    .set_data (set_data)
  );
endmodule

// File: rtl/ser_set_rx_chk.sv
module ser_set_rx_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              set_stb,
  input logic [ADDR_W-1:0] set_addr,
  input logic [DATA_W-1:0] set_data,
  input logic [2:0]        state,
  input logic [CNT_W-1:0]  cnt,
  input logic              start_evt,
  input logic              stop_evt
);
  import ser_set_pkg::*;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !set_stb); // R1
  AST_IDLE_WAITS_START: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_evt) |=> state == ST_IDLE); // R2
  AST_STB_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
    set_stb |-> ($past(state) == ST_DATA && state == ST_WAIT)); // R3
  AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> !set_stb); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !set_stb |-> ($stable(set_addr) && $stable(set_data))); // R5
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (state == ST_ADDR && cnt == '0 && !set_stb)); // R6
  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (state == ST_IDLE && !set_stb)); // R7
  AST_WAIT_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !start_evt && !stop_evt) |=> (state == ST_WAIT && !set_stb)); // R8
endmodule

bind ser_set_rx ser_set_rx_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .set_stb   (set_stb),
  .set_addr  (set_addr),
  .set_data  (set_data),
  .state     (state_q),
  .cnt       (cnt_q),
  .start_evt (start_evt),
  .stop_evt  (stop_evt)
);

// File: tb/ser_set_rx_tb.sv
module ser_set_rx_tb;
  localparam int HALF = 4;
  localparam int NVEC = 6;
  localparam logic [39:0] VEC [NVEC] = '{
    40'h00_000001B2, 40'h03_00000005, 40'hFF_FFFFFFFF,
    40'h80_00000001, 40'h01_80000000, 40'hA5_5A5AA5A5
  };

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1;
  logic        set_stb;
  logic [7:0]  set_addr;
  logic [31:0] set_data;
  int checks = 0, failures = 0;
  int stb_count = 0, run_len = 0, max_run = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_set_rx u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data)
  );

  always @(posedge clk) begin
    if (set_stb) begin
      stb_count <= stb_count + 1;
      run_len   <= run_len + 1;
      if (run_len + 1 > max_run) max_run <= run_len + 1;
    end else begin
      run_len <= 0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_start();
    scl <= 1'b0; waitn(HALF);
    sda <= 1'b1; waitn(HALF);
    scl <= 1'b1; waitn(HALF);
    sda <= 1'b0; waitn(HALF);
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      scl <= 1'b0; sda <= v[i]; waitn(HALF);
      scl <= 1'b1; waitn(HALF);
    end
  endtask

  task automatic send_stop();
    scl <= 1'b0; sda <= 1'b0; waitn(HALF);
    scl <= 1'b1; waitn(HALF);
    sda <= 1'b1; waitn(HALF * 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    waitn(6);
    chk("R1 stb in reset", set_stb, 0);
    rst <= 1'b0;
    waitn(4);
    chk("R1 stb after reset", set_stb, 0);
    chk("R1 addr after reset", set_addr, 0);
    chk("R1 data after reset", set_data, 0);

    // Table walk: R3 field order and R4 one strobe per frame
    for (int k = 0; k < NVEC; k++) begin
      base = stb_count;
      send_start();
      send_bits(64'(VEC[k]), 40);
      send_stop();
      chk("R4 one strobe per frame", stb_count - base, 1);
      chk("R3 address", set_addr, 64'(VEC[k][39:32]));
      chk("R3 data", set_data, 64'(VEC[k][31:0]));
    end
    chk("R4 strobe width", max_run, 1);

    // R5 hold between frames
    waitn(50);
    chk("R5 addr hold", set_addr, 8'hA5);
    chk("R5 data hold", set_data, 32'h5A5AA5A5);

    // R2 bits without a start
    base = stb_count;
    scl <= 1'b0; waitn(HALF);
    send_bits(64'h12_3456789A, 40);
    waitn(20);
    chk("R2 no strobe without start", stb_count - base, 0);
    chk("R2 addr unchanged", set_addr, 8'hA5);
    chk("R2 data unchanged", set_data, 32'h5A5AA5A5);
    send_stop();

    // R7 stop mid-frame
    base = stb_count;
    send_start();
    send_bits(64'hC3_F0F, 20);
    send_stop();
    chk("R7 no strobe on early stop", stb_count - base, 0);
    chk("R7 addr kept", set_addr, 8'hA5);
    chk("R7 data kept", set_data, 32'h5A5AA5A5);

    // R6 restart mid-frame
    base = stb_count;
    send_start();
    send_bits(64'h3FF, 10);
    send_start();
    send_bits(64'h5C_DEADBEEF, 40);
    send_stop();
    chk("R6 one strobe after restart", stb_count - base, 1);
    chk("R6 addr after restart", set_addr, 8'h5C);
    chk("R6 data after restart", set_data, 32'hDEADBEEF);

    // R8 extra clocks after the 40th bit
    base = stb_count;
    send_start();
    send_bits(64'h7E_01234567, 40);
    send_bits(64'h15, 5);
    send_stop();
    chk("R8 single strobe with extra bits", stb_count - base, 1);
    chk("R8 addr", set_addr, 8'h7E);
    chk("R8 data", set_data, 32'h01234567);
    chk("R4 strobe width final", max_run, 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule